// File: doc/BRIEF.md
# Grouped Interrupt Mask Controller

This block gathers one-cycle event strobes from the transmit and receive engines of a network controller and latches each one into a sticky status bit. Each status bit is gated by its own source enable. The gated sources are then merged into two summary groups: a normal group for routine completions, and an abnormal group for stalls, underruns and timeouts. Each group has its own group enable. The two gated group terms are OR-ed and registered to give one level-sensitive interrupt line.

The host sees two 32-bit registers through a single read/write port. `reg_sel` picks which one. The mask register holds the eight source enables and the two group enables. The event register holds the sticky status bits and two read-only summary flags. Writing a one to a status bit clears it. The handler reads the event register, finds the cause, and clears only what it has serviced.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset, both registers read zero and `irq` is low.
- R2: The mask register (`reg_sel`=0) stores written bits 0-3, 5-8 (source enables), bit 15 (abnormal group enable) and bit 16 (normal group enable). Each stored bit reads back as written, and every other bit reads zero.
- R3: Position 4 is reserved. In both registers it always reads zero, a write to it has no effect, and a strobe on `evt_strobe[4]` sets nothing.
- R4: A strobe on `evt_strobe[i]` sets event-register bit i (i in 0-3, 5-8) at the next clock edge. The bit stays set until the host clears it.
- R5: A write to the event register (`reg_sel`=1) clears each status bit whose data bit is one. Status bits whose data bit is zero are unchanged.
- R6: If a strobe and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Event-register bit 16 reads as the OR of (status AND source enable) over the normal sources 0, 2 and 6. Bit 15 reads as the same OR over the abnormal sources 1, 3, 5, 7 and 8. Writes to bits 15 and 16 of this register have no effect.
- R8: `irq` equals, one cycle later, (normal summary AND bit-16 group enable) OR (abnormal summary AND bit-15 group enable).
- R9: A set status bit whose source enable is zero never raises `irq` or a summary flag. A group with its enable cleared never raises `irq`.
- R10: A write to one register leaves the contents of the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the selected register |
| reg_sel | input | 1 | 0 selects the mask register, 1 selects the event register |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Read data of the selected register (combinational) |
| evt_strobe | input | 9 | One-cycle event pulses; index matches the status bit |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench drives a strobe and a one-to-clear write onto the same bit in the same cycle. A design that let the clear win would lose that event and read the bit back as zero. It sets status bits while their source enables or group enables are off, and expects `irq` to stay low. A design that skipped either gate would raise a spurious interrupt. It writes ones to the reserved position and to the read-only summary positions, and expects them to read back as the rules dictate. A design that stored those bits would show extra ones. It also times `irq` one cycle after each change in status or mask. A design that made the line combinational, or added a stage, would miss on every compare.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int SRC_W       = 9;
  localparam int DATA_W      = 32;
  localparam int ABN_EN_BIT  = 15;
  localparam int NORM_EN_BIT = 16;
  // group membership of each source position
  localparam logic [SRC_W-1:0] NORM_MASK = 9'h045;  // sources 0, 2, 6
  localparam logic [SRC_W-1:0] ABN_MASK  = 9'h1AA;  // sources 1, 3, 5, 7, 8
  localparam logic [SRC_W-1:0] LIVE_MASK = NORM_MASK | ABN_MASK;

  typedef struct packed {
    logic norm;
    logic abn;
  } grp_pair_t;

  // summary of one group: any source both pending and enabled
  function automatic logic grp_hit(input logic [SRC_W-1:0] st,
                                   input logic [SRC_W-1:0] en,
                                   input logic [SRC_W-1:0] mask);
    return |(st & en & mask);
  endfunction

  // sticky update: clear by one-writes, new events take priority
  function automatic logic [SRC_W-1:0] sticky_next(input logic [SRC_W-1:0] st,
                                                   input logic [SRC_W-1:0] set,
                                                   input logic [SRC_W-1:0] clr);
    return (st & ~clr) | set;
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_grp_pkg::*;
#(
  parameter int                N_SRC = SRC_W,
  parameter logic [N_SRC-1:0]  LIVE  = LIVE_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_bits,
  input  logic             clr_en,
  input  logic [N_SRC-1:0] clr_bits,
  output logic [N_SRC-1:0] status
);
  logic [N_SRC-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_bits : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_bits[i] | (q & ~clr_eff[i]);
      end
      assign status[i] = q;
    end else begin : g_rsvd
      assign status[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_grp_pkg::*;
#(
  parameter int                N_SRC = SRC_W,
  parameter logic [N_SRC-1:0]  LIVE  = LIVE_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [N_SRC-1:0] src_wd,
  input  logic             norm_wd,
  input  logic             abn_wd,
  output logic [N_SRC-1:0] src_en,
  output grp_pair_t        grp_en
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_en
    if (LIVE[i]) begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (wr) q <= src_wd[i];
      end
      assign src_en[i] = q;
    end else begin : g_rsvd
      assign src_en[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_en <= '0;
    end else if (wr) begin
      grp_en.norm <= norm_wd;
      grp_en.abn  <= abn_wd;
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_grp_pkg::*;
#(
  parameter int               N_SRC = SRC_W,
  parameter logic [N_SRC-1:0] NORM  = NORM_MASK,
  parameter logic [N_SRC-1:0] ABN   = ABN_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] status,
  input  logic [N_SRC-1:0] src_en,
  input  grp_pair_t        grp_en,
  output grp_pair_t        summary,
  output logic             irq
);
  logic irq_next;

  assign summary.norm = grp_hit(status, src_en, NORM);
  assign summary.abn  = grp_hit(status, src_en, ABN);
  assign irq_next     = (summary.norm & grp_en.norm) | (summary.abn & grp_en.abn);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [SRC_W-1:0]  evt_strobe,
  output logic              irq
);
  localparam logic SEL_MASK = 1'b0;
  localparam logic SEL_EVT  = 1'b1;

  logic             mask_wr;
  logic             evt_wr;
  logic [SRC_W-1:0] status;
  logic [SRC_W-1:0] src_en;
  grp_pair_t        grp_en;
  grp_pair_t        summary;
  logic             unused_wr_bits;

  assign mask_wr = wr_en & (reg_sel == SEL_MASK);
  assign evt_wr  = wr_en & (reg_sel == SEL_EVT);
  assign unused_wr_bits = ^wr_data;

  irq_status_bank #(.N_SRC(SRC_W), .LIVE(LIVE_MASK)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (evt_strobe & LIVE_MASK),
    .clr_en   (evt_wr),
    .clr_bits (wr_data[SRC_W-1:0]),
    .status   (status)
  );

  irq_enable_regs #(.N_SRC(SRC_W), .LIVE(LIVE_MASK)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (mask_wr),
    .src_wd  (wr_data[SRC_W-1:0]),
    .norm_wd (wr_data[NORM_EN_BIT]),
    .abn_wd  (wr_data[ABN_EN_BIT]),
    .src_en  (src_en),
    .grp_en  (grp_en)
  );

  irq_combiner #(.N_SRC(SRC_W), .NORM(NORM_MASK), .ABN(ABN_MASK)) u_comb (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status),
    .src_en  (src_en),
    .grp_en  (grp_en),
    .summary (summary),
    .irq     (irq)
  );

  always_comb begin
    rd_data = '0;
    if (reg_sel == SEL_EVT) begin
      rd_data[SRC_W-1:0]  = status;
      rd_data[NORM_EN_BIT] = summary.norm;
      rd_data[ABN_EN_BIT]  = summary.abn;
    end else begin
      rd_data[SRC_W-1:0]  = src_en;
      rd_data[NORM_EN_BIT] = grp_en.norm;
      rd_data[ABN_EN_BIT]  = grp_en.abn;
    end
  end
endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk
  import irq_grp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             reg_sel,
  input logic [SRC_W-1:0] wr_lo,
  input logic [SRC_W-1:0] evt_strobe,
  input logic [SRC_W-1:0] status,
  input logic [SRC_W-1:0] src_en,
  input logic             grp_norm_en,
  input logic             grp_abn_en,
  input logic             irq
);
  logic [SRC_W-1:0] gate_vec;
  assign gate_vec = ({SRC_W{grp_norm_en}} & NORM_MASK) | ({SRC_W{grp_abn_en}} & ABN_MASK);

  // R8: interrupt follows the gated pending sources one cycle later
  p_irq_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(status & src_en & gate_vec))));

  // R4: without a host clear, no status bit ever drops
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_sel) |=> ((status & $past(status)) == $past(status)));

  // R6: a strobed bit is set next cycle, clear or not
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_strobe & LIVE_MASK)) |=>
      ((status & $past(evt_strobe & LIVE_MASK)) == $past(evt_strobe & LIVE_MASK)));

  // R5: cleared bits are zero next cycle when no event competes
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && (evt_strobe == '0)) |=> ((status & $past(wr_lo)) == '0));

  // R3: reserved position never holds state
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] == 1'b0) && (src_en[4] == 1'b0));

  // R9: both groups disabled means no interrupt next cycle
  p_grp_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_norm_en && !grp_abn_en) |=> !irq);
endmodule

bind irq_group_ctrl irq_group_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .reg_sel     (reg_sel),
  .wr_lo       (wr_data[8:0]),
  .evt_strobe  (evt_strobe),
  .status      (status),
  .src_en      (src_en),
  .grp_norm_en (grp_en.norm),
  .grp_abn_en  (grp_en.abn),
  .irq         (irq)
);

// File: tb/irq_group_ctrl_bench.sv
module irq_group_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [8:0]  evt = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_st [9];
  bit m_en [9];
  bit m_gn, m_ga, m_irq;

  always #10 clk = ~clk;

  irq_group_ctrl u_irq_group_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .evt_strobe(evt), .irq(irq)
  );

  function automatic bit is_norm(int i); return (i == 0) || (i == 2) || (i == 6); endfunction
  function automatic bit is_live(int i); return i != 4; endfunction

  function automatic bit sum_norm();
    for (int i = 0; i < 9; i++) if (is_norm(i) && m_st[i] && m_en[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit sum_abn();
    for (int i = 0; i < 9; i++) if (is_live(i) && !is_norm(i) && m_st[i] && m_en[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_mask();
    logic [31:0] v = '0;
    for (int i = 0; i < 9; i++) v[i] = m_en[i];
    v[16] = m_gn;
    v[15] = m_ga;
    return v;
  endfunction

  function automatic logic [31:0] exp_evt();
    logic [31:0] v = '0;
    for (int i = 0; i < 9; i++) v[i] = m_st[i];
    v[16] = sum_norm();
    v[15] = sum_abn();
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    reg_sel = 1'b0; #1;
    chk(tag, "mask register", rd_data, exp_mask());
    reg_sel = 1'b1; #1;
    chk(tag, "event register", rd_data, exp_evt());
    chk(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic step(string tag, bit we, bit sel, logic [31:0] wd, logic [8:0] ev);
    bit nirq;
    @(negedge clk);
    compare(tag);
    wr_en = we; reg_sel = sel; wr_data = wd; evt = ev;
    @(posedge clk);
    nirq = (sum_norm() && m_gn) || (sum_abn() && m_ga);
    for (int i = 0; i < 9; i++) begin
      if (is_live(i)) begin
        m_st[i] = ev[i] || (m_st[i] && !(we && sel && wd[i]));
        if (we && !sel) m_en[i] = wd[i];
      end
    end
    if (we && !sel) begin
      m_gn = wd[16];
      m_ga = wd[15];
    end
    m_irq = nirq;
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b0, 32'h0, 9'h0);
  endtask

  initial begin
    for (int i = 0; i < 9; i++) begin m_st[i] = 0; m_en[i] = 0; end
    m_gn = 0; m_ga = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");                                      // reset state
    step("R2", 1, 0, 32'hFFFF_FFFF, 9'h0);           // all ones to mask
    idle("R2");                                      // R3: bit 4 reads zero
    step("R2", 1, 0, 32'h0001_0155, 9'h0);           // pattern readback
    step("R2", 1, 0, 32'h0, 9'h0);
    step("R3", 0, 0, 32'h0, 9'h010);                 // reserved strobe only
    idle("R3");
    step("R4", 0, 0, 32'h0, 9'h1EF);                 // all live strobes
    idle("R9");                                      // no enables: irq low
    idle("R4");
    step("R9", 1, 0, 32'h0000_01EF, 9'h0);           // sources on, groups off
    idle("R7");
    idle("R9");
    step("R8", 1, 0, 32'h0001_01EF, 9'h0);           // normal group on
    idle("R8");
    step("R5", 1, 1, 32'h0000_0045, 9'h0);           // clear normal sources
    idle("R8");                                      // irq drops
    step("R5", 1, 1, 32'h0, 9'h0);                   // zero write: no change
    step("R8", 1, 0, 32'h0000_81EF, 9'h0);           // abnormal group only
    idle("R8");
    step("R10", 1, 1, 32'h0001_8000, 9'h0);          // summary bits read-only
    idle("R7");
    step("R5", 1, 1, 32'h0000_01AA, 9'h0);
    idle("R8");
    step("R6", 1, 1, 32'h0000_0008, 9'h008);         // set and clear collide
    idle("R6");
    step("R10", 1, 0, 32'h0001_8002, 9'h0);          // mask write keeps status
    idle("R10");
    step("R9", 1, 0, 32'h0000_8000, 9'h0);           // group on, sources off
    idle("R9");
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r1, r2;
      r1 = $urandom; r2 = $urandom;
      step("R8", (r1[3:0] < 4'd4), r1[5], r2, 9'((r1 >> 8) & (r1 >> 17)));
    end
    idle("R8");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule